// File: doc/BRIEF.md
# Truth-Table Configuration Generator

This block turns a short run of decoded two-source instructions into the three 16-entry truth tables that program a carry-based functional unit: a generate table, a propagate table and an output table. Each instruction is AND, OR, XOR or ADD. It names two source registers and a destination register. The block evaluates the run symbolically: every architectural register holds a 16-bit table in a small meta register file, and each instruction combines the tables of its sources bitwise and writes the result to its destination. Logic placed before or after the single adder therefore folds into the programmable tables.

A register that is read before anything in the run has written it is a live-in. Each live-in receives the next free canonical input-variable pattern. The carry variable has its own fixed pattern. An ADD records the AND and the XOR of its source tables as the generate and propagate tables. Its destination then receives the propagate table XOR the carry pattern. When the end marker arrives, the block registers the destination table of the last instruction as the output table. It shows all three tables for one cycle, together with a flag for runs it cannot map.

The control is a three-state machine. ST_IDLE waits for a beat with the start marker. ST_BODY accepts instructions. ST_DONE presents the result for one cycle. The transitions are as follows:
- idle_to_body: a start beat without the end marker.
- idle_to_done: a start beat with the end marker.
- body_to_body: a beat without the end marker, or a start beat, which restarts the run.
- body_to_done: a beat with the end marker.
- done_to_idle: no start beat in the done cycle.
- done_to_body and done_to_done: a start beat in the done cycle.

Top module: `cfg_truthgen`

## Requirements
- R1: After reset, cfg_valid is 0, cfg_err is 0, cfg_gen is 16'h0000, cfg_prop is 16'hFFFF and cfg_out is 16'h0000.
- R2: Within a run, the first, second and third distinct live-in registers read receive the tables 16'h5555, 16'h3333 and 16'h00FF. A register used as both sources reads one table. A register read after a write in the run uses the written table.
- R3: in_op encodes 0 as AND, 1 as OR and 2 as XOR. The destination table is the bitwise AND, OR or XOR of the two source tables.
- R4: in_op 3 is ADD. cfg_gen becomes A AND B, cfg_prop becomes A XOR B, and the destination table becomes (A XOR B) XOR 16'h0F0F.
- R5: When a beat with in_end is accepted, cfg_valid is 1 in the next cycle only. cfg_out then equals the destination table of that beat.
- R6: A run without ADD reports cfg_gen = 16'h0000 and cfg_prop = 16'hFFFF.
- R7: A run with a second ADD, or with an ADD whose source depends on the carry, reports cfg_err = 1.
- R8: A run that needs a fourth distinct live-in register reports cfg_err = 1.
- R9: When the machine is not in a run, beats without in_start are ignored and cfg_valid stays 0. A beat with in_start discards the run in progress, including its tables, live-ins and error.
- R10: A run with no mapping fault reports cfg_err = 0, even directly after a run that had a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction beat present |
| in_start | input | 1 | Beat is the first of a run |
| in_end | input | 1 | Beat is the last of a run |
| in_op | input | 2 | Operation: 0 AND, 1 OR, 2 XOR, 3 ADD |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| in_dst | input | REG_W | Destination register |
| cfg_valid | output | 1 | Tables valid this cycle |
| cfg_gen | output | 16 | Generate table |
| cfg_prop | output | 16 | Propagate table |
| cfg_out | output | 16 | Output table |
| cfg_err | output | 1 | Run could not be mapped |

## Verification
The assertions assume that in_valid, in_start and in_end are 0 during reset. They also assume that the marker inputs are known whenever in_valid is 1. The bench keeps this by holding in_valid low through reset. It drives all inputs only at falling edges, and it zeroes the markers whenever no beat is sent. Runs are kept back to back or separated by idle cycles, so every end marker is followed by a clean done cycle before the next run starts.

// File: rtl/cfg_truthgen_pkg.sv
package cfg_truthgen_pkg;

    localparam int TBL_W    = 16;
    localparam int LIVE_MAX = 3;

    typedef logic [TBL_W-1:0] tbl_t;

    typedef enum logic [1:0] {OP_AND = 2'd0, OP_OR = 2'd1, OP_XOR = 2'd2, OP_ADD = 2'd3} op_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BODY = 2'd1, ST_DONE = 2'd2} st_e;

    localparam tbl_t PAT_V0    = 16'h5555;
    localparam tbl_t PAT_V1    = 16'h3333;
    localparam tbl_t PAT_CARRY = 16'h0F0F;
    localparam tbl_t PAT_V3    = 16'h00FF;

    // canonical variable pattern handed to the n-th live-in of a run
    function automatic tbl_t live_pat(input logic [1:0] idx);
        case (idx)
            2'd0:    return PAT_V0;
            2'd1:    return PAT_V1;
            2'd2:    return PAT_V3;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_meta_rf.sv
module cfg_meta_rf
    import cfg_truthgen_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             clear,
    input  logic [REG_W-1:0] rd_a,
    input  logic [REG_W-1:0] rd_b,
    output tbl_t             tbl_a,
    output logic             def_a,
    output logic             dep_a,
    output tbl_t             tbl_b,
    output logic             def_b,
    output logic             dep_b,
    input  logic             seed_a,
    input  tbl_t             seed_a_tbl,
    input  logic             seed_b,
    input  tbl_t             seed_b_tbl,
    input  logic [REG_W-1:0] wr_dst,
    input  tbl_t             wr_tbl,
    input  logic             wr_dep
);
    localparam int NREG = 1 << REG_W;

    tbl_t            mem [NREG];
    logic [NREG-1:0] def_q;
    logic [NREG-1:0] dep_q;

    assign tbl_a = mem[rd_a];
    assign tbl_b = mem[rd_b];
    assign def_a = def_q[rd_a] & ~clear;
    assign def_b = def_q[rd_b] & ~clear;
    assign dep_a = dep_q[rd_a];
    assign dep_b = dep_q[rd_b];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            def_q <= '0;
            dep_q <= '0;
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < NREG; i++) begin
                if (REG_W'(i) == wr_dst) begin
                    mem[i]   <= wr_tbl;
                    def_q[i] <= 1'b1;
                    dep_q[i] <= wr_dep;
                end else if (seed_a && REG_W'(i) == rd_a) begin
                    mem[i]   <= seed_a_tbl;
                    def_q[i] <= 1'b1;
                    dep_q[i] <= 1'b0;
                end else if (seed_b && REG_W'(i) == rd_b) begin
                    mem[i]   <= seed_b_tbl;
                    def_q[i] <= 1'b1;
                    dep_q[i] <= 1'b0;
                end else if (clear) begin
                    def_q[i] <= 1'b0;
                end
            end
        end
    end

    // R2: a written destination is known to the run on the following cycle
    a_r2_dst_defined: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> def_q[$past(wr_dst)]);

endmodule

// File: rtl/cfg_eval.sv
module cfg_eval
    import cfg_truthgen_pkg::*;
(
    input  op_e  op,
    input  tbl_t ta,
    input  tbl_t tb,
    output tbl_t res,
    output tbl_t gen,
    output tbl_t prop
);
    assign gen  = ta & tb;
    assign prop = ta ^ tb;

    always_comb begin
        unique case (op)
            OP_AND:  res = ta & tb;
            OP_OR:   res = ta | tb;
            OP_XOR:  res = ta ^ tb;
            OP_ADD:  res = prop ^ PAT_CARRY;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/cfg_truthgen.sv
module cfg_truthgen
    import cfg_truthgen_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic             in_end,
    input  logic [1:0]       in_op,
    input  logic [REG_W-1:0] in_src_a,
    input  logic [REG_W-1:0] in_src_b,
    input  logic [REG_W-1:0] in_dst,
    output logic             cfg_valid,
    output logic [15:0]      cfg_gen,
    output logic [15:0]      cfg_prop,
    output logic [15:0]      cfg_out,
    output logic             cfg_err
);
    st_e state, state_nx;

    logic       accept, is_add, same_src;
    logic       new_a, new_b, dep_a_eff, dep_b_eff, over, err_now;
    logic [1:0] live_q, live_base, idx_b;
    logic [2:0] live_next;
    logic       add_q, err_q, add_prev, err_base;
    tbl_t       g_q, p_q, g_base, p_base, g_nx, p_nx;
    tbl_t       tbl_a, tbl_b, ta, tb, res, gen, prop;
    logic       def_a, def_b, dep_a, dep_b;
    op_e        op;

    assign op       = op_e'(in_op);
    assign accept   = in_valid && (in_start || state == ST_BODY);
    assign is_add   = (op == OP_ADD);
    assign same_src = (in_src_a == in_src_b);

    cfg_meta_rf #(.REG_W(REG_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(accept), .clear(accept && in_start),
        .rd_a(in_src_a), .rd_b(in_src_b),
        .tbl_a(tbl_a), .def_a(def_a), .dep_a(dep_a),
        .tbl_b(tbl_b), .def_b(def_b), .dep_b(dep_b),
        .seed_a(new_a), .seed_a_tbl(ta), .seed_b(new_b), .seed_b_tbl(tb),
        .wr_dst(in_dst), .wr_tbl(res), .wr_dep(is_add | dep_a_eff | dep_b_eff)
    );

    // live-in allocation and operand selection
    always_comb begin
        live_base = in_start ? 2'd0 : live_q;
        new_a     = !def_a;
        new_b     = !def_b && !same_src;
        idx_b     = live_base + {1'b0, new_a};
        live_next = {1'b0, live_base} + {2'b0, new_a} + {2'b0, new_b};
        over      = live_next > 3'(LIVE_MAX);
        ta        = new_a ? live_pat(live_base) : tbl_a;
        tb        = same_src ? ta : (new_b ? live_pat(idx_b) : tbl_b);
        dep_a_eff = !new_a && dep_a;
        dep_b_eff = same_src ? dep_a_eff : (!new_b && dep_b);
    end

    cfg_eval u_eval (.op(op), .ta(ta), .tb(tb), .res(res), .gen(gen), .prop(prop));

    // run accumulation
    always_comb begin
        add_prev = in_start ? 1'b0 : add_q;
        err_base = in_start ? 1'b0 : err_q;
        g_base   = in_start ? 16'h0000 : g_q;
        p_base   = in_start ? 16'hFFFF : p_q;
        err_now  = over | (is_add & (add_prev | dep_a_eff | dep_b_eff));
        g_nx     = is_add ? gen : g_base;
        p_nx     = is_add ? prop : p_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            add_q  <= 1'b0;
            err_q  <= 1'b0;
            g_q    <= 16'h0000;
            p_q    <= 16'hFFFF;
        end else if (accept) begin
            live_q <= over ? 2'd3 : live_next[1:0];
            add_q  <= add_prev | is_add;
            err_q  <= err_base | err_now;
            g_q    <= g_nx;
            p_q    <= p_nx;
        end
    end

    // state machine: next-state logic and state register
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (accept)                state_nx = in_end ? ST_DONE : ST_BODY;
                else if (state == ST_DONE) state_nx = ST_IDLE;
            end
            ST_BODY: if (accept && in_end) state_nx = ST_DONE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_gen  <= 16'h0000;
            cfg_prop <= 16'hFFFF;
            cfg_out  <= 16'h0000;
            cfg_err  <= 1'b0;
        end else if (accept && in_end) begin
            cfg_gen  <= g_nx;
            cfg_prop <= p_nx;
            cfg_out  <= res;
            cfg_err  <= err_base | err_now;
        end
    end

    assign cfg_valid = (state == ST_DONE);

    a_r5_valid_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_end) |=> cfg_valid);
    a_r5_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(accept && in_end));
    a_r4_gen_prop_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ((cfg_gen & cfg_prop) == 16'h0000));
    a_r7_second_add: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_start && add_q && is_add) |=> err_q);
    a_r8_live_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && over) |=> err_q);

endmodule

// File: tb/test_cfg_truthgen.sv
`timescale 1ns/1ps
module test_cfg_truthgen;
    localparam int REG_W = 4;
    localparam logic [1:0] AND_ = 2'd0, OR_ = 2'd1, XOR_ = 2'd2, ADD_ = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
    logic [1:0] in_op = '0;
    logic [REG_W-1:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic cfg_valid, cfg_err;
    logic [15:0] cfg_gen, cfg_prop, cfg_out;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_truthgen #(.REG_W(REG_W)) i_cfg_truthgen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start), .in_end(in_end),
        .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
        .cfg_valid(cfg_valid), .cfg_gen(cfg_gen), .cfg_prop(cfg_prop),
        .cfg_out(cfg_out), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic beat(input logic st, input logic en, input logic [1:0] op,
                        input int a, input int b, input int d);
        @(negedge clk);
        in_valid = 1'b1; in_start = st; in_end = en; in_op = op;
        in_src_a = REG_W'(a); in_src_b = REG_W'(b); in_dst = REG_W'(d);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
    endtask

    // call after the end beat: checks the done cycle, then the cycle after it
    task automatic expect_cfg(input string tag, input logic [15:0] g, input logic [15:0] p,
                              input logic [15:0] o, input logic e);
        idle();
        chk({tag, " R5 valid"}, {15'b0, cfg_valid}, 16'h1);
        chk({tag, " gen"}, cfg_gen, g);
        chk({tag, " prop"}, cfg_prop, p);
        chk({tag, " out"}, cfg_out, o);
        chk({tag, " err"}, {15'b0, cfg_err}, {15'b0, e});
        idle();
        chk({tag, " R5 valid drops"}, {15'b0, cfg_valid}, 16'h0);
    endtask

    task automatic t_reset();
        chk("R1 valid", {15'b0, cfg_valid}, 16'h0);
        chk("R1 err", {15'b0, cfg_err}, 16'h0);
        chk("R1 gen", cfg_gen, 16'h0000);
        chk("R1 prop", cfg_prop, 16'hFFFF);
        chk("R1 out", cfg_out, 16'h0000);
    endtask

    task automatic t_mixed_add();   // R3 R4: AND, ADD, XOR of both results
        beat(1, 0, AND_, 1, 2, 3);
        beat(0, 0, ADD_, 1, 2, 4);
        beat(0, 1, XOR_, 3, 4, 5);
        expect_cfg("R4 mixed", 16'h1111, 16'h6666, 16'h7878, 1'b0);
    endtask

    task automatic t_logic_only();  // R3 R6
        beat(1, 1, OR_, 1, 2, 3);
        expect_cfg("R6 or only", 16'h0000, 16'hFFFF, 16'h7777, 1'b0);
        beat(1, 1, AND_, 1, 1, 2);
        expect_cfg("R2 same source", 16'h0000, 16'hFFFF, 16'h5555, 1'b0);
    endtask

    task automatic t_single_add();  // R4
        beat(1, 1, ADD_, 1, 2, 4);
        expect_cfg("R4 lone add", 16'h1111, 16'h6666, 16'h6969, 1'b0);
    endtask

    task automatic t_three_live(); // R2: third live-in gets 00FF
        beat(1, 0, XOR_, 1, 2, 5);
        beat(0, 1, AND_, 5, 3, 6);
        expect_cfg("R2 third live", 16'h0000, 16'hFFFF, 16'h0066, 1'b0);
        beat(1, 0, ADD_, 1, 2, 4);
        beat(0, 1, XOR_, 4, 3, 5);
        expect_cfg("R2 add plus live", 16'h1111, 16'h6666, 16'h6996, 1'b0);
        beat(1, 0, OR_, 1, 2, 1);   // r1 rewritten to 7777
        beat(0, 1, AND_, 1, 2, 3);  // 7777 & 3333
        expect_cfg("R2 rewritten reg", 16'h0000, 16'hFFFF, 16'h3333, 1'b0);
    endtask

    task automatic t_four_live();   // R8
        beat(1, 0, AND_, 1, 2, 5);
        beat(0, 1, OR_, 3, 4, 6);
        idle();
        chk("R8 fourth live err", {15'b0, cfg_err}, 16'h1);
        idle();
    endtask

    task automatic t_second_add();  // R7
        beat(1, 0, ADD_, 1, 2, 4);
        beat(0, 1, ADD_, 4, 3, 5);
        idle();
        chk("R7 second add err", {15'b0, cfg_err}, 16'h1);
        idle();
    endtask

    task automatic t_clean_after_error(); // R10
        beat(1, 1, XOR_, 1, 2, 3);
        expect_cfg("R10 clean run", 16'h0000, 16'hFFFF, 16'h6666, 1'b0);
    endtask

    task automatic t_ignore_and_restart(); // R9
        beat(0, 1, ADD_, 1, 2, 4);
        idle();
        chk("R9 no start ignored", {15'b0, cfg_valid}, 16'h0);
        beat(1, 0, ADD_, 1, 2, 4);
        beat(1, 1, ADD_, 6, 7, 5);
        expect_cfg("R9 restart", 16'h1111, 16'h6666, 16'h6969, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mixed_add();
        t_logic_only();
        t_single_add();
        t_three_live();
        t_four_live();
        t_clean_after_error();
        t_second_add();
        t_clean_after_error();
        t_ignore_and_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule